// File: doc/BRIEF.md
# Mode-Selectable Write Buffer with Program Timer

This block sits between a serial-bus front end and a nonvolatile byte array. The front end passes it the data bytes of one write command as a valid/ready stream. The block stores them in a small buffer. A single-cycle `stop` strobe closes the command. The block then runs a self-timed program cycle: it writes the buffered bytes to the array, one strobe per clock, and holds `busy` high for a program time set by a parameter. `busy` keeps the front end locked out until the cycle ends.

The `mode` pin picks the buffer rules for a command.

- **Page write (`mode` = 0):** the block keeps up to one 16-byte row. The byte position wraps inside that row.
- **Multibyte write (`mode` = 1):** the block accepts up to 8 bytes from any start address, and the address may run into the next row. If the start address is the first byte of a row, it accepts a whole row of 16 bytes.

The program time is `PROG_TICKS` clock cycles. It doubles when a multibyte command touches two rows.

Stream rules:
- A byte transfers on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is low for the whole program cycle, and a source must hold its byte until it is accepted.
- `in_addr` is read only on the first byte of a command. Each later byte goes to the next location.

Top module: `wbuf_prog`

## Requirements
- R1: After reset, `busy` is low, `in_ready` is high and `arr_we` is low.
- R2: Page mode. The k-th byte of a command (k from 0) goes to the address whose upper 7 bits are those of the start address and whose low 4 bits are (start low 4 bits + k) mod 16. A later byte that lands in the same position replaces the earlier one, and each position is written at most once.
- R3: Multibyte mode with a start address not on a row boundary. The k-th byte goes to start + k, modulo 2048. Only the first 8 bytes are stored; further bytes are accepted and dropped.
- R4: Multibyte mode with a start address whose low 4 bits are 0. Up to 16 bytes are stored, at start + k.
- R5: A command of one byte writes that byte to the start address in either mode.
- R6: `stop` while not busy starts the program cycle if at least one byte was accepted, counting a byte accepted in the same cycle. `stop` with no byte does nothing.
- R7: `busy` stays high for exactly `PROG_TICKS` cycles. It stays high for 2*`PROG_TICKS` cycles when the command is multibyte and the first and last stored addresses differ in their upper 7 bits.
- R8: While `busy` is high, `in_ready` is low. Bytes offered and `stop` pulses during that time are ignored.
- R9: When `busy` falls the buffer empties, so the next command writes none of the earlier bytes.
- R10: A byte accepted in the same cycle as `stop` belongs to the command that `stop` closes.
- R11: The value of `mode` sampled with the first byte governs the whole command. Changes to `mode` later in the command have no effect.
- R12: Array writes happen only while `busy` is high, at most one per cycle, and never twice in a row to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken (low while busy) |
| in_addr | input | 11 | Byte address, used on the first byte only |
| in_data | input | 8 | Data byte |
| stop | input | 1 | End-of-command strobe |
| mode | input | 1 | 1 = multibyte write, 0 = page write |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 11 | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |

## Verification
Two events can land on the same clock edge: the capture of the last byte and the `stop` strobe that closes the command. The random commands set `stop` together with the last byte about half the time, and separately one cycle after it the rest of the time. A bench model then expects that byte to be written and expects the doubled program time whenever that byte is the one that carries the command into a second row. The same model compares the whole array image and the length of `busy` after every command.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {
    WMODE_PAGE  = 1'b0,
    WMODE_MULTI = 1'b1
  } wmode_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 4,
  parameter int MB_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mode_i,
  input  logic              clear,
  input  logic [ROW_W-1:0]  rd_slot,
  output logic              have_o,
  output wmode_e            mode_o,
  output logic [ADDR_W-1:0] start_o,
  output logic              slot_full_o,
  output logic [DATA_W-1:0] slot_data_o,
  output logic              span_o
);
  localparam int SLOTS = 1 << ROW_W;
  localparam int CW    = ROW_W + 1;

  logic              have_q;
  wmode_e            mode_q;
  logic [ADDR_W-1:0] start_q;
  logic [ROW_W-1:0]  beat_q;
  logic [CW-1:0]     stored_q;
  logic [SLOTS-1:0]  full_q;
  logic [DATA_W-1:0] data_q [SLOTS];

  logic [ADDR_W-1:0] eff_start;
  wmode_e            eff_mode;
  logic [ROW_W-1:0]  k_page;
  logic [CW-1:0]     k_mb, limit;
  logic [ROW_W-1:0]  wr_slot;
  logic              wr_en;
  logic [ADDR_W-1:0] last_addr;

  always_comb begin
    eff_start = have_q ? start_q : addr_i;
    eff_mode  = have_q ? mode_q : wmode_e'(mode_i);
    k_page    = have_q ? beat_q : '0;
    k_mb      = have_q ? stored_q : '0;
    limit     = (eff_start[ROW_W-1:0] == '0) ? CW'(SLOTS) : CW'(MB_MAX);
    if (eff_mode == WMODE_PAGE) begin
      wr_slot = eff_start[ROW_W-1:0] + k_page;
      wr_en   = accept;
    end else begin
      wr_slot = k_mb[ROW_W-1:0];
      wr_en   = accept && (k_mb < limit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have_q   <= 1'b0;
      mode_q   <= WMODE_PAGE;
      start_q  <= '0;
      beat_q   <= '0;
      stored_q <= '0;
      full_q   <= '0;
    end else if (accept) begin
      have_q  <= 1'b1;
      mode_q  <= eff_mode;
      start_q <= eff_start;
      beat_q  <= k_page + 1'b1;
      if (wr_en) begin
        full_q[wr_slot] <= 1'b1;
        stored_q        <= k_mb + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_slot] <= data_i;
  end

  assign last_addr   = start_q + ADDR_W'(stored_q) - ADDR_W'(1);
  assign span_o      = (mode_q == WMODE_MULTI) &&
                       (last_addr[ADDR_W-1:ROW_W] != start_q[ADDR_W-1:ROW_W]);
  assign have_o      = have_q;
  assign mode_o      = mode_q;
  assign start_o     = start_q;
  assign slot_full_o = full_q[rd_slot];
  assign slot_data_o = data_q[rd_slot];
endmodule

// File: rtl/wbuf_timer.sv
module wbuf_timer #(
  parameter int PROG_TICKS = 32,
  parameter int ROW_W      = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           dbl,
  output logic           busy_o,
  output logic           scan_on,
  output logic [ROW_W-1:0] scan_slot,
  output logic           fin
);
  localparam int SLOTS = 1 << ROW_W;
  localparam int TW    = $clog2(PROG_TICKS + 1);
  localparam int SW    = ROW_W + 1;

  logic          busy_q, second_q;
  logic [TW-1:0] cnt_q;
  logic [SW-1:0] scan_q;
  logic          at_end;

  assign at_end = busy_q && (cnt_q == '0);
  assign fin    = at_end && !(dbl && !second_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      second_q <= 1'b0;
      cnt_q    <= '0;
      scan_q   <= '0;
    end else if (!busy_q) begin
      if (go) begin
        busy_q   <= 1'b1;
        second_q <= 1'b0;
        cnt_q    <= TW'(PROG_TICKS - 1);
        scan_q   <= '0;
      end
    end else begin
      if (scan_q != SW'(SLOTS)) scan_q <= scan_q + 1'b1;
      if (fin) begin
        busy_q <= 1'b0;
      end else if (at_end) begin
        second_q <= 1'b1;
        cnt_q    <= TW'(PROG_TICKS - 1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign scan_on   = busy_q && (scan_q < SW'(SLOTS));
  assign scan_slot = scan_q[ROW_W-1:0];
endmodule

// File: rtl/wbuf_prog.sv
module wbuf_prog
  import wbuf_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int ROW_W      = 4,
  parameter int MB_MAX     = 8,
  parameter int PROG_TICKS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              stop,
  input  logic              mode,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy
);
  logic              accept, go, fin, have, span, scan_on, slot_full;
  logic [ROW_W-1:0]  scan_slot;
  logic [ADDR_W-1:0] start;
  wmode_e            cmd_mode;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign go       = stop && !busy && (have || accept);

  wbuf_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .MB_MAX(MB_MAX)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept), .addr_i(in_addr),
    .data_i(in_data), .mode_i(mode), .clear(fin), .rd_slot(scan_slot),
    .have_o(have), .mode_o(cmd_mode), .start_o(start),
    .slot_full_o(slot_full), .slot_data_o(arr_data), .span_o(span)
  );

  wbuf_timer #(.PROG_TICKS(PROG_TICKS), .ROW_W(ROW_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .dbl(span), .busy_o(busy),
    .scan_on(scan_on), .scan_slot(scan_slot), .fin(fin)
  );

  assign arr_we   = scan_on && slot_full;
  assign arr_addr = (cmd_mode == WMODE_MULTI) ? start + ADDR_W'(scan_slot)
                                              : {start[ADDR_W-1:ROW_W], scan_slot};
endmodule

// File: rtl/wbuf_prog_chk.sv
module wbuf_prog_chk #(
  parameter int ADDR_W     = 11,
  parameter int PROG_TICKS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              stop,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              busy
);
  logic [31:0] blen;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) blen <= '0;
    else                 blen <= blen + 1;
  end

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !in_ready); // R8
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) arr_we |-> busy); // R12
  AST_START_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(stop)); // R6
  AST_NO_REPEAT_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (arr_we && $past(arr_we)) |-> (arr_addr != $past(arr_addr))); // R12
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (blen == PROG_TICKS || blen == 2 * PROG_TICKS)); // R7
endmodule

bind wbuf_prog wbuf_prog_chk #(.ADDR_W(ADDR_W), .PROG_TICKS(PROG_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .stop(stop),
  .arr_we(arr_we), .arr_addr(arr_addr), .busy(busy)
);

// File: tb/wbuf_prog_test.sv
module wbuf_prog_test;
  localparam int P = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, stop = 1'b0, mode = 1'b1;
  logic [10:0] in_addr = '0;
  logic [7:0]  in_data = '0;
  logic        in_ready, arr_we, busy;
  logic [10:0] arr_addr;
  logic [7:0]  arr_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] exp_mem [2048];
  logic [7:0] obs_mem [2048];
  logic [7:0] cmd_data [32];
  int wr_cnt = 0;

  always #2.5 clk = ~clk;

  wbuf_prog #(.PROG_TICKS(P)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .stop(stop), .mode(mode),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy)
  );

  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      obs_mem[arr_addr] = arr_data;
      wr_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_len(input bit md, input logic [10:0] st, input int n);
    int m;
    logic [10:0] last;
    if (!md) return P;
    m = (n < ((st[3:0] == 0) ? 16 : 8)) ? n : ((st[3:0] == 0) ? 16 : 8);
    last = st + 11'(m - 1);
    return (last[10:4] != st[10:4]) ? 2 * P : P;
  endfunction

  function automatic int model(input bit md, input logic [10:0] st, input int n);
    bit [15:0] touched = '0;
    int lim, m;
    logic [3:0] s;
    if (!md) begin
      for (int k = 0; k < n; k++) begin
        s = st[3:0] + 4'(k);
        exp_mem[{st[10:4], s}] = cmd_data[k];
        touched[s] = 1'b1;
      end
      return $countones(touched);
    end
    lim = (st[3:0] == 0) ? 16 : 8;
    m = (n < lim) ? n : lim;
    for (int k = 0; k < m; k++) exp_mem[st + 11'(k)] = cmd_data[k];
    return m;
  endfunction

  task automatic run_cmd(input bit md, input logic [10:0] st, input int n,
                         input bit stop_same, input string req);
    int ewr, elen, blen, mism;
    wr_cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_addr  = (k == 0) ? st : 11'($urandom);
      in_data  = cmd_data[k];
      mode     = (k == 0) ? md : 1'($urandom);
      stop     = stop_same && (k == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    stop     = !stop_same;
    if (!stop_same) @(negedge clk);
    stop = 1'b0;
    ewr  = model(md, st, n);
    elen = exp_len(md, st, n);
    blen = stop_same ? 1 : 0;
    if (!stop_same) blen = busy ? 1 : 0;
    while (busy && blen < 4 * P) begin
      @(negedge clk);
      if (busy) blen++;
    end
    check(blen == elen, {req, " R7 busy length"}, blen, elen);
    check(wr_cnt == ewr, {req, " write count"}, wr_cnt, ewr);
    mism = 0;
    for (int a = 0; a < 2048; a++) if (obs_mem[a] !== exp_mem[a]) mism++;
    check(mism == 0, {req, " array image"}, mism, 0);
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) cmd_data[k] = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hold;
    void'($urandom(32'd1234));
    for (int a = 0; a < 2048; a++) begin exp_mem[a] = 8'h00; obs_mem[a] = 8'h00; end
    repeat (3) @(negedge clk);
    check(busy == 0 && in_ready == 1 && arr_we == 0, "R1 reset outputs",
          {busy, in_ready, arr_we}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && in_ready == 1, "R1 after release", {busy, in_ready}, 2'b01);

    // R6: stop alone does nothing
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 0, "R6 empty stop", busy, 0);

    fill(20); run_cmd(1'b0, 11'h1F3, 20, 1'b0, "R2 page wrap overwrite");
    fill(8);  run_cmd(1'b1, 11'h0FA, 8, 1'b0, "R3 multibyte span R7 double");
    fill(12); run_cmd(1'b1, 11'h105, 12, 1'b1, "R3 multibyte discard R10");
    fill(16); run_cmd(1'b1, 11'h200, 16, 1'b0, "R4 aligned sixteen");
    fill(1);  run_cmd(1'b0, 11'h333, 1, 1'b1, "R5 single page");
    fill(1);  run_cmd(1'b1, 11'h334, 1, 1'b0, "R5 single multibyte");
    fill(2);  run_cmd(1'b1, 11'h7FF, 2, 1'b1, "R3 address wrap");
    fill(5);  run_cmd(1'b0, 11'h02E, 5, 1'b1, "R11 mode held page");

    // R8 / R9: offers during busy ignored, buffer empty afterwards
    fill(3);
    @(negedge clk); in_valid = 1; in_addr = 11'h440; in_data = 8'h5A; mode = 0; stop = 1;
    @(negedge clk); in_valid = 1; in_data = 8'hC3; stop = 1;
    check(in_ready == 0, "R8 ready low in busy", in_ready, 0);
    hold = 0;
    while (busy && hold < 4 * P) begin @(negedge clk); hold++; stop = 0; end
    in_valid = 0; stop = 0;
    exp_mem[11'h440] = 8'h5A;
    check(obs_mem[11'h440] == 8'h5A, "R8 first byte only", obs_mem[11'h440], 8'h5A);
    check(obs_mem[11'h441] == exp_mem[11'h441], "R8 busy byte dropped",
          obs_mem[11'h441], exp_mem[11'h441]);
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
    repeat (2) @(negedge clk);
    check(busy == 0, "R9 buffer empty after cycle", busy, 0);

    for (int i = 0; i < 40; i++) begin
      int n = 1 + ($urandom % 20);
      bit md = 1'($urandom);
      logic [10:0] st = 11'($urandom);
      if ((i % 5) == 0) st[3:0] = 4'h0;
      fill(n);
      run_cmd(md, st, n, 1'($urandom), md ? "R3 R4 R10 random multibyte" : "R2 R10 random page");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule